// File: doc/BRIEF.md
# Receive Destination Address Filter

This block decides whether an incoming Ethernet frame is kept or discarded, based only on its 48-bit destination address. The address enters as six bytes on a valid/ready byte stream, the first byte on the wire first. Once the sixth byte is taken, the block produces one accept-or-drop result.

A frame is kept when any enabled check succeeds. The checks are:
- an exact match with either of two programmable station addresses;
- the all-ones broadcast address;
- a hit in a 64-entry group hash table.

The hash index folds the address into six bits by XOR-ing its eight 6-bit slices. The table therefore behaves as a one-hash Bloom filter: every joined group passes, and some groups that were not joined may pass too.

Software-facing settings are written through a plain 32-bit write port and held in shadow registers. They are copied into the working set only when a new frame begins, so the settings never change in the middle of a comparison.

Back-pressure rules:
- The source keeps `byte_valid` and `byte_data` steady until a cycle where both `byte_valid` and `byte_ready` are high. That cycle transfers the byte.
- `byte_ready` drops for exactly one cycle after the sixth byte is taken, while the decision is formed.
- At all other times `byte_ready` is high.

Top module: `rx_dest_filter`

## Requirements
- R1: Settings are written when `cfg_we` is high, at the register chosen by `cfg_sel`:
  - 0: control;
  - 1: station address A, low word;
  - 2: station address A, high word;
  - 3: station address B, low word;
  - 4: station address B, high word;
  - 5: table bits 31:0;
  - 6: table bits 63:32.
  
  Control bits: bit 0 enables station A, bit 1 enables station B, bit 2 applies the hash to every address, bit 3 enables broadcast.
- R2: With control bit 0 set, a frame whose address equals station A is accepted. In the low word, bits 7:0 hold stream byte 0, and bytes 1 to 3 follow upward. Bits 15:0 of the high word hold bytes 4 (low) and 5. A mismatch in any single byte does not produce a station-A match.
- R3: With control bit 1 set, a frame whose address equals station B, laid out as in R2, is accepted. Station A does not match while bit 0 is clear.
- R4: With control bit 3 set, the address with all 48 bits set is accepted. An address with any bit clear is not accepted by this check.
- R5: Let A[8i+7:8i] be stream byte i. The hash index is A[5:0] ^ A[11:6] ^ ... ^ A[47:42]. An index below 32 selects that bit of table bits 31:0, and an index of 32 or more selects table bit index. A set table bit accepts the frame.
- R6: When control bit 2 is clear, the hash check applies only to group addresses, meaning bit 0 of byte 0 is 1. When control bit 2 is set, it applies to every address.
- R7: A frame for which no enabled check succeeds is dropped (`decision_accept` is 0).
- R8: `decision_done` is a one-cycle pulse in the cycle after the one in which the sixth byte is taken. `byte_ready` is low for exactly the cycle between them.
- R9: `decision_accept` keeps its value from the `decision_done` cycle until the first byte of the next frame is taken, and then reads 0.
- R10: Settings are applied when a frame's first byte is taken. A write made during a frame, including in the same cycle as its first byte, takes effect from the next frame.
- R11: After reset, `decision_done` and `decision_accept` are 0, `byte_ready` is 1, and all settings are 0, so every frame is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Setting write strobe |
| cfg_sel | input | 3 | Setting register select |
| cfg_wdata | input | 32 | Setting write data |
| byte_valid | input | 1 | Address byte valid |
| byte_ready | output | 1 | Filter can take a byte |
| byte_data | input | 8 | Address byte, first on wire first |
| decision_done | output | 1 | One-cycle result strobe |
| decision_accept | output | 1 | 1 keeps the frame, 0 drops it |

## Verification
The hash path is driven by a sweep over all 64 table positions. For each position, one address hashes onto the single set table bit and must pass, and a one-bit-flipped neighbour must fail. This tells a correct slice fold and word split apart from an off-by-one slice or a swapped table half.

Station matching is tried with the exact address and with six variants, each differing in one byte. This separates a correct byte order from a partial or reversed compare. Broadcast is tried with all ones and with a single clear bit.

Group-versus-individual gating is exercised with a full table under both settings of the hash-all bit. Writes landing in the first byte of a frame and in the middle of a frame show whether the settings are snapshotted at the frame start.

// File: rtl/dfa_pkg.sv
package dfa_pkg;
  localparam int ADDR_BYTES = 6;
  localparam int ADDR_W     = ADDR_BYTES * 8;
  localparam int HASH_W     = 6;
  localparam int TBL_BITS   = 1 << HASH_W;
  localparam int REG_W      = 32;
  localparam int CNT_W      = $clog2(ADDR_BYTES);
  localparam int HI_BITS    = ADDR_W - REG_W;

  typedef enum logic [2:0] {
    SEL_CTRL   = 3'd0,
    SEL_UA0_LO = 3'd1,
    SEL_UA0_HI = 3'd2,
    SEL_UA1_LO = 3'd3,
    SEL_UA1_HI = 3'd4,
    SEL_TBL_LO = 3'd5,
    SEL_TBL_HI = 3'd6
  } cfg_sel_e;

  typedef struct packed {
    logic                en_ua0;
    logic                en_ua1;
    logic                hash_all;
    logic                en_bcast;
    logic [ADDR_W-1:0]   ua0;
    logic [ADDR_W-1:0]   ua1;
    logic [TBL_BITS-1:0] table_bits;
  } filt_cfg_t;

  // Folds one byte, arriving at position idx, into the slice-XOR hash.
  function automatic logic [HASH_W-1:0] byte_fold(input logic [CNT_W-1:0] idx,
                                                  input logic [7:0] b);
    logic [HASH_W-1:0] r;
    int pos;
    r = '0;
    for (int j = 0; j < 8; j++) begin
      pos = int'(idx) * 8 + j;
      r[pos % HASH_W] = r[pos % HASH_W] ^ b[j];
    end
    return r;
  endfunction
endpackage

// File: rtl/dfa_cfg_regs.sv
module dfa_cfg_regs
  import dfa_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [2:0]       sel,
  input  logic [REG_W-1:0] wdata,
  input  logic             load,
  output filt_cfg_t        active
);
  filt_cfg_t shadow;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shadow <= '0;
    end else if (we) begin
      case (cfg_sel_e'(sel))
        SEL_CTRL: begin
          shadow.en_ua0   <= wdata[0];
          shadow.en_ua1   <= wdata[1];
          shadow.hash_all <= wdata[2];
          shadow.en_bcast <= wdata[3];
        end
        SEL_UA0_LO: shadow.ua0[REG_W-1:0]       <= wdata;
        SEL_UA0_HI: shadow.ua0[ADDR_W-1:REG_W]  <= wdata[HI_BITS-1:0];
        SEL_UA1_LO: shadow.ua1[REG_W-1:0]       <= wdata;
        SEL_UA1_HI: shadow.ua1[ADDR_W-1:REG_W]  <= wdata[HI_BITS-1:0];
        SEL_TBL_LO: shadow.table_bits[REG_W-1:0]        <= wdata;
        SEL_TBL_HI: shadow.table_bits[TBL_BITS-1:REG_W] <= wdata;
        default: ;
      endcase
    end
  end

  // Working copy refreshed only at a frame boundary.
  always_ff @(posedge clk) begin
    if (!rst_n)    active <= '0;
    else if (load) active <= shadow;
  end
endmodule

// File: rtl/dfa_collect.sv
module dfa_collect
  import dfa_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [7:0]        in_data,
  output logic              in_ready,
  output logic              take_first,
  output logic              deciding,
  output logic [ADDR_W-1:0] addr,
  output logic [HASH_W-1:0] hash
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(ADDR_BYTES - 1);

  logic [CNT_W-1:0] cnt;
  logic             take;

  assign in_ready   = !deciding;
  assign take       = in_valid && in_ready;
  assign take_first = take && (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt      <= '0;
      deciding <= 1'b0;
      hash     <= '0;
    end else begin
      deciding <= take && (cnt == LAST);
      if (take) begin
        cnt  <= (cnt == LAST) ? '0 : cnt + 1'b1;
        hash <= ((cnt == '0) ? '0 : hash) ^ byte_fold(cnt, in_data);
      end
    end
  end

  for (genvar g = 0; g < ADDR_BYTES; g++) begin : g_byte
    always_ff @(posedge clk) begin
      if (!rst_n)                              addr[g*8 +: 8] <= '0;
      else if (take && cnt == CNT_W'(g))       addr[g*8 +: 8] <= in_data;
    end
  end
endmodule

// File: rtl/dfa_decide.sv
module dfa_decide
  import dfa_pkg::*;
(
  input  filt_cfg_t         cfg,
  input  logic [ADDR_W-1:0] addr,
  input  logic [HASH_W-1:0] hash,
  output logic              keep
);
  logic hit_ua0, hit_ua1, hit_bcast, hit_hash, is_group;

  assign is_group  = addr[0];
  assign hit_ua0   = cfg.en_ua0   && (addr == cfg.ua0);
  assign hit_ua1   = cfg.en_ua1   && (addr == cfg.ua1);
  assign hit_bcast = cfg.en_bcast && (&addr);
  assign hit_hash  = (cfg.hash_all || is_group) && cfg.table_bits[hash];
  assign keep      = hit_ua0 || hit_ua1 || hit_bcast || hit_hash;
endmodule

// File: rtl/rx_dest_filter.sv
module rx_dest_filter
  import dfa_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [2:0]       cfg_sel,
  input  logic [REG_W-1:0] cfg_wdata,
  input  logic             byte_valid,
  output logic             byte_ready,
  input  logic [7:0]       byte_data,
  output logic             decision_done,
  output logic             decision_accept
);
  filt_cfg_t         cfg_act;
  logic              take_first, deciding, keep;
  logic [ADDR_W-1:0] addr;
  logic [HASH_W-1:0] hash;

  dfa_cfg_regs u_cfg (
    .clk, .rst_n, .we(cfg_we), .sel(cfg_sel), .wdata(cfg_wdata),
    .load(take_first), .active(cfg_act)
  );

  dfa_collect u_col (
    .clk, .rst_n, .in_valid(byte_valid), .in_data(byte_data),
    .in_ready(byte_ready), .take_first, .deciding, .addr, .hash
  );

  dfa_decide u_dec (.cfg(cfg_act), .addr, .hash, .keep);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      decision_done   <= 1'b0;
      decision_accept <= 1'b0;
    end else begin
      decision_done <= deciding;
      if (take_first)    decision_accept <= 1'b0;
      else if (deciding) decision_accept <= keep;
    end
  end
endmodule

// File: rtl/dfa_checker.sv
module dfa_checker (
  input logic clk,
  input logic rst_n,
  input logic byte_valid,
  input logic byte_ready,
  input logic decision_done,
  input logic decision_accept
);
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    decision_done |=> !decision_done);

  a_r8_stall_then_done: assert property (@(posedge clk) disable iff (!rst_n)
    !byte_ready |=> (decision_done && byte_ready));

  a_r9_accept_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_ready && !(byte_valid && byte_ready)) |=> $stable(decision_accept));

  a_r9_rise_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(decision_accept) |-> decision_done);
endmodule

bind rx_dest_filter dfa_checker u_chk (
  .clk(clk), .rst_n(rst_n), .byte_valid(byte_valid), .byte_ready(byte_ready),
  .decision_done(decision_done), .decision_accept(decision_accept)
);

// File: tb/sim_rx_dest_filter.sv
`timescale 1ns/1ps
module sim_rx_dest_filter;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [2:0] cfg_sel = '0;
  logic [31:0] cfg_wdata = '0;
  logic byte_valid = 1'b0;
  logic [7:0] byte_data = '0;
  logic byte_ready, decision_done, decision_accept;

  int checks = 0, fails = 0;
  logic [3:0]  m_ctrl = '0;
  logic [47:0] m_ua0 = '0, m_ua1 = '0;
  logic [63:0] m_tbl = '0;
  logic        got_acc, first_acc;

  always #2.5 clk = ~clk;

  rx_dest_filter u0 (.*);

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [5:0] ref_hash(input logic [47:0] a);
    logic [5:0] h = '0;
    for (int k = 0; k < 8; k++) h ^= a[6*k +: 6];
    return h;
  endfunction

  function automatic logic ref_keep(input logic [47:0] a);
    logic k;
    k = (m_ctrl[0] && a == m_ua0) || (m_ctrl[1] && a == m_ua1) ||
        (m_ctrl[3] && &a) || ((m_ctrl[2] || a[0]) && m_tbl[ref_hash(a)]);
    return k;
  endfunction

  task automatic wr(input logic [2:0] sel, input logic [31:0] d);
    @(negedge clk); cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk); cfg_we = 1'b0;
    case (sel)
      3'd0: m_ctrl = d[3:0];
      3'd1: m_ua0[31:0] = d;
      3'd2: m_ua0[47:32] = d[15:0];
      3'd3: m_ua1[31:0] = d;
      3'd4: m_ua1[47:32] = d[15:0];
      3'd5: m_tbl[31:0] = d;
      3'd6: m_tbl[63:32] = d;
      default: ;
    endcase
  endtask

  // Sends one address; optional write on byte wb (wb > 5 means none).
  task automatic send_w(input logic [47:0] a, input int wb, input logic [2:0] sel,
                        input logic [31:0] d);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (i == 1) first_acc = decision_accept;
      byte_valid = 1'b1; byte_data = a[8*i +: 8];
      cfg_we = (i == wb); cfg_sel = sel; cfg_wdata = d;
    end
    @(negedge clk); byte_valid = 1'b0; cfg_we = 1'b0;
    chk(!byte_ready && !decision_done, "R8 stall cycle", {byte_ready, decision_done}, 2'b00);
    @(negedge clk);
    chk(decision_done && byte_ready, "R8 done strobe", {decision_done, byte_ready}, 2'b11);
    got_acc = decision_accept;
    @(negedge clk);
    chk(!decision_done, "R8 done one cycle", decision_done, 0);
    chk(decision_accept == got_acc, "R9 hold", decision_accept, got_acc);
  endtask

  task automatic send_chk(input logic [47:0] a, input string tag);
    logic e;
    e = ref_keep(a);
    send_w(a, 9, 3'd0, 32'd0);
    chk(got_acc == e, tag, got_acc, e);
  endtask

  task automatic finish_run;
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    logic [47:0] sa, sb, p, a;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk(!decision_done && !decision_accept && byte_ready, "R11 reset outputs",
        {decision_done, decision_accept, byte_ready}, 3'b001);
    send_w({48{1'b1}}, 9, 3'd0, 0);
    chk(got_acc == 1'b0, "R11 cleared settings drop", got_acc, 0);

    // R1 R2 station A
    sa = 48'h5e_40_93_1c_a2_08;
    wr(3'd1, sa[31:0]); wr(3'd2, {16'hffff, sa[47:32]}); wr(3'd0, 32'h1);
    send_chk(sa, "R2 station A exact");
    chk(got_acc == 1'b1, "R1 R2 accept", got_acc, 1);
    send_w(48'h0, 9, 3'd0, 0);
    chk(first_acc == 1'b0, "R9 cleared on first byte", first_acc, 0);
    send_w(sa, 9, 3'd0, 0);
    for (int b = 0; b < 6; b++) begin
      a = sa ^ (48'h10 << (8*b));
      send_chk(a, "R2 single byte mismatch");
    end
    wr(3'd0, 32'h0);
    send_chk(sa, "R7 station A disabled");

    // R3 station B
    sb = 48'h11_22_33_44_55_66;
    wr(3'd3, sb[31:0]); wr(3'd4, {16'h0, sb[47:32]}); wr(3'd0, 32'h2);
    send_chk(sb, "R3 station B exact");
    send_chk(sa, "R3 station A off");
    send_chk(sb ^ 48'h8000_0000_0000, "R3 mismatch");

    // R4 broadcast
    wr(3'd0, 32'h8);
    send_chk({48{1'b1}}, "R4 broadcast");
    send_chk({{47{1'b1}}, 1'b0}, "R4 near broadcast");
    send_chk(sb, "R7 broadcast only");

    // R5 sweep of all table positions
    wr(3'd0, 32'h4);
    p = 48'h3c_a5_71_0e_d2_96;
    for (int k = 0; k < 64; k++) begin
      wr(3'd5, (k < 32) ? (32'h1 << k) : 32'h0);
      wr(3'd6, (k >= 32) ? (32'h1 << (k - 32)) : 32'h0);
      a = {p[47:6], 6'(k) ^ ref_hash({p[47:6], 6'h0})};
      send_chk(a, "R5 table hit");
      a = a ^ (48'h1 << (6*(k % 8) + (k % 6)));
      send_chk(a, "R5 neighbour miss");
    end

    // R6 group gating
    wr(3'd5, 32'hffff_ffff); wr(3'd6, 32'hffff_ffff); wr(3'd0, 32'h0);
    send_chk(48'h00_00_00_00_00_01, "R6 group hashed");
    send_chk(48'h00_00_00_00_00_02, "R6 individual skipped");
    wr(3'd0, 32'h4);
    send_chk(48'h00_00_00_00_00_02, "R6 hash all");
    wr(3'd5, 32'h0); wr(3'd6, 32'h0);

    // R10 mid-frame writes
    wr(3'd0, 32'h1);
    send_w(sa, 2, 3'd0, 32'h0);
    chk(got_acc == 1'b1, "R10 mid-frame write deferred", got_acc, 1);
    m_ctrl = 4'h0;
    send_chk(sa, "R10 applied next frame");
    send_w(sa, 0, 3'd0, 32'h1);
    chk(got_acc == 1'b0, "R10 first-byte write deferred", got_acc, 0);
    m_ctrl = 4'h1;
    send_chk(sa, "R10 applied after first-byte write");

    finish_run();
  end
endmodule